// File: doc/BRIEF.md
# Timed Key-Combination Reset Detector

This block turns a chord of four active-low key lines into a reset request. A static two-bit selector sets which lines form the chord. The chord counts only when every line in it is low at once. The lines first pass through a two-flop synchronizer. After that, a qualification counter clocked by the 32.768 kHz low-speed clock must see the chord held without a break for `QUAL_CYCLES` cycles before the request is raised. The default of 65536 cycles is two seconds. A key pressed by accident therefore does not reset the chip.

When the system is in standby, or is waiting for its oscillator to settle, the counter is not needed. In those states the request follows the synchronized chord straight away. The request is a level. It stays high for as long as the chord is held and drops soon after any line in the chord is released.

Top module: `keycombo_reset`

## Requirements
- R1: `combo_sel_i` encodes the chord: 0 = disabled, 1 = lines 0 and 1, 2 = lines 0, 1 and 2, 3 = lines 0 to 3. Bit i of `key_n_i` is line i, and a line is pressed when it is 0.
- R2: With `combo_sel_i` = 0, `reset_req_o` stays 0 whatever the key lines do and however long they are held.
- R3: A request needs every selected line to be low. Any selected line at 1 blocks the request. Lines outside the selection have no effect.
- R4: With both bypass flags low, suppose the chord is held low starting before clock edge 1. `reset_req_o` is still 0 after edge `QUAL_CYCLES`+1 and is 1 after edge `QUAL_CYCLES`+2.
- R5: If any selected line goes high before the request is raised, the counter returns to zero. A new press must then wait the full qualification time again.
- R6: While `standby_i` or `osc_wait_i` is 1, suppose the chord goes low before clock edge 1. `reset_req_o` is 1 after edge 3.
- R7: `reset_req_o` stays 1 while the chord stays low. If a selected line goes high before edge 1, the request is 0 after edge 3.
- R8: Key lines are seen only through a two-flop synchronizer. A chord that goes low before edge 1 has not raised the request after edge 2, even in bypass.
- R9: The counter keeps running during bypass. Suppose a bypass flag falls while the chord is still held. If the count has not reached its end, the request drops after the next edge and rises again once the qualification time, counted from the start of the press, has passed.
- R10: After `rst_n` is released, `reset_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n_i | input | 4 | Active-low key lines, asynchronous |
| combo_sel_i | input | 2 | Static chord selector (R1 encoding) |
| standby_i | input | 1 | System in standby; bypasses the timer |
| osc_wait_i | input | 1 | Oscillator-settle wait; bypasses the timer |
| reset_req_o | output | 1 | Reset request level |

## Verification
The bypass path and the qualification counter's terminal count can both decide the request in the same cycle. The bench provokes this by pressing the chord with a bypass flag high and dropping the flag part way through the count. It checks that the request falls on the next edge. It then checks that the request rises again on the exact edge where the counter, which kept running through the bypass, reaches its end. A second case holds the chord in bypass past the terminal count before dropping the flag, and checks that the request never falls.

// File: rtl/keycombo_pkg.sv
package keycombo_pkg;
  localparam int KC_LINES = 4;

  typedef enum logic [1:0] {
    COMBO_OFF   = 2'd0,
    COMBO_L01   = 2'd1,
    COMBO_L012  = 2'd2,
    COMBO_L0123 = 2'd3
  } combo_e;
endpackage

// File: rtl/kc_sync.sv
module kc_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_n_i,
  output logic [WIDTH-1:0] sync_n_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // One two-flop chain per line; idle level (high) out of reset.
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b1;
        stage2_q[i] <= 1'b1;
      end else begin
        stage1_q[i] <= async_n_i[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign sync_n_o = stage2_q;
endmodule

// File: rtl/kc_match.sv
module kc_match
  import keycombo_pkg::*;
#(
  parameter int WIDTH = KC_LINES
) (
  input  combo_e           sel_i,
  input  logic [WIDTH-1:0] line_n_i,
  output logic             match_o
);
  logic [WIDTH-1:0] mask;

  // Line i belongs to the chord when the selector is not OFF and i <= code.
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    localparam int unsigned IDX = i;
    assign mask[i] = (sel_i != COMBO_OFF) && (IDX <= 32'(sel_i));
  end

  assign match_o = (mask != '0) && ((~line_n_i & mask) == mask);
endmodule

// File: rtl/kc_qual_timer.sv
module kc_qual_timer #(
  parameter int QUAL_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic bypass_i,
  output logic req_o
);
  localparam int CNT_W = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             at_end;

  assign at_end = (cnt_q == LAST);

  // Counter saturates at LAST and clears whenever the chord breaks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!match_i) cnt_q <= '0;
    else if (!at_end)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= match_i && (bypass_i || at_end);
  end

  assign req_o = req_q;

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !match_i |=> !req_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !match_i |=> (cnt_q == '0));
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && bypass_i) |=> req_o);
  p_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !bypass_i && !at_end) |=> !req_o);
  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && at_end) |=> req_o);
endmodule

// File: rtl/keycombo_reset.sv
module keycombo_reset
  import keycombo_pkg::*;
#(
  parameter int QUAL_CYCLES = 65536
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [KC_LINES-1:0] key_n_i,
  input  logic [1:0]          combo_sel_i,
  input  logic                standby_i,
  input  logic                osc_wait_i,
  output logic                reset_req_o
);
  logic [KC_LINES-1:0] key_sync_n;
  logic                chord;
  combo_e              sel;

  assign sel = combo_e'(combo_sel_i);

  kc_sync #(.WIDTH(KC_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_n_i(key_n_i),
    .sync_n_o (key_sync_n)
  );

  kc_match #(.WIDTH(KC_LINES)) u_match (
    .sel_i   (sel),
    .line_n_i(key_sync_n),
    .match_o (chord)
  );

  kc_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .match_i (chord),
    .bypass_i(standby_i || osc_wait_i),
    .req_o   (reset_req_o)
  );

  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (combo_sel_i == 2'd0) |=> !reset_req_o);
  p_needs_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (combo_sel_i != 2'd0 && key_sync_n[0]) |=> !reset_req_o);
endmodule

// File: tb/keycombo_reset_bench.sv
`timescale 1ns/1ps
module keycombo_reset_bench;
  localparam int QUAL = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] keys = 4'hF;
  logic [1:0] sel = 2'd0;
  logic       stby = 1'b0;
  logic       oscw = 1'b0;
  logic       req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keycombo_reset #(.QUAL_CYCLES(QUAL)) u_keycombo_reset (
    .clk(clk), .rst_n(rst_n), .key_n_i(keys), .combo_sel_i(sel),
    .standby_i(stby), .osc_wait_i(oscw), .reset_req_o(req)
  );

  // {sel[1:0], key_n[3:0], expected}, all applied in bypass (R1, R3, R6)
  localparam logic [6:0] VEC [16] = '{
    {2'd0, 4'b0000, 1'b0}, {2'd1, 4'b1100, 1'b1}, {2'd1, 4'b1110, 1'b0},
    {2'd1, 4'b1101, 1'b0}, {2'd1, 4'b0000, 1'b1}, {2'd2, 4'b1000, 1'b1},
    {2'd2, 4'b1100, 1'b0}, {2'd2, 4'b1010, 1'b0}, {2'd2, 4'b1001, 1'b0},
    {2'd2, 4'b0000, 1'b1}, {2'd3, 4'b0000, 1'b1}, {2'd3, 4'b0001, 1'b0},
    {2'd3, 4'b1000, 1'b0}, {2'd3, 4'b0100, 1'b0}, {2'd1, 4'b0011, 1'b0},
    {2'd0, 4'b1111, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: reset_req_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic release_all();
    @(negedge clk);
    keys = 4'hF; stby = 1'b0; oscw = 1'b0;
    edges(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk); rst_n = 1'b1;
    #1 check(req, 1'b0, "R10 reset state");

    // Table walk in bypass
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sel  = VEC[i][6:5];
      keys = VEC[i][4:1];
      stby = (i % 2 == 0);
      oscw = (i % 2 == 1);
      edges(3);
      check(req, VEC[i][0], $sformatf("R1/R3/R6 vector %0d", i));
      release_all();
    end

    // R8: two-flop delay, then R6 bypass edge
    @(negedge clk); sel = 2'd3; keys = 4'b0000; oscw = 1'b1;
    edges(2);
    check(req, 1'b0, "R8 not yet after edge 2");
    edges(1);
    check(req, 1'b1, "R6 high after edge 3");
    // R7: hold, then release one selected line
    edges(20);
    check(req, 1'b1, "R7 held while chord low");
    @(negedge clk); keys = 4'b0100;
    edges(2);
    check(req, 1'b1, "R7 still high after edge 2");
    edges(1);
    check(req, 1'b0, "R7 low after edge 3 of release");
    release_all();

    // R4: normal qualification timing
    @(negedge clk); sel = 2'd2; keys = 4'b1000;
    edges(QUAL + 1);
    check(req, 1'b0, "R4 low after edge QUAL+1");
    edges(1);
    check(req, 1'b1, "R4 high after edge QUAL+2");
    release_all();

    // R5: break before terminal, restart full wait
    @(negedge clk); sel = 2'd1; keys = 4'b1100;
    edges(QUAL - 5);
    @(negedge clk); keys = 4'b1101;
    edges(3);
    @(negedge clk); keys = 4'b1100;
    edges(QUAL + 1);
    check(req, 1'b0, "R5 restarted count not done at QUAL+1");
    edges(1);
    check(req, 1'b1, "R5 high after full restart QUAL+2");
    release_all();

    // R2: disabled, held for long
    @(negedge clk); sel = 2'd0; keys = 4'b0000;
    edges(QUAL + 10);
    check(req, 1'b0, "R2 disabled never requests");
    release_all();

    // R9: bypass drops mid-count
    @(negedge clk); sel = 2'd3; keys = 4'b0000; stby = 1'b1;
    edges(10);
    check(req, 1'b1, "R9 high during bypass");
    @(negedge clk); stby = 1'b0;
    edges(1);
    check(req, 1'b0, "R9 drops when bypass leaves before terminal");
    edges(QUAL + 1 - 11);
    check(req, 1'b0, "R9 still low at edge QUAL+1");
    edges(1);
    check(req, 1'b1, "R9 rises at edge QUAL+2 of press");
    release_all();

    // R9: bypass drops after terminal, request never falls
    @(negedge clk); sel = 2'd3; keys = 4'b0000; oscw = 1'b1;
    edges(QUAL + 5);
    @(negedge clk); oscw = 1'b0;
    edges(1);
    check(req, 1'b1, "R9 stays high after terminal");
    edges(5);
    check(req, 1'b1, "R9 still high later");
    release_all();
    check(req, 1'b0, "R7 low after full release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule